// File: doc/BRIEF.md
# I2C Bus Monitor and Recovery Control

This block sits beside an I2C master's byte engine. It resynchronises the shared SCL and SDA lines and watches them for bus conditions. A START (SDA falling while SCL is high) marks the bus as occupied. A STOP (SDA rising while SCL is high) marks it free again and sets a stop-seen flag. The synchronised levels of both lines are also brought out as a two-bit readback, so software can observe the raw bus.

A two-bit control register decides who owns the pins. When its run bit is clear, the byte engine is held in reset and SDA is never pulled low. SCL then follows the register's release bit: a 0 drives the line low and a 1 lets it float. Software uses this to toggle SCL by hand and clock a stuck slave free, watching SDA on the readback. Writing run=1 together with release=1 hands the pins back to the engine. The engine's reset is held for one extra cycle so that it starts idle with both lines released.

Top module: `i2c_busmon_recover`

## Requirements
- R1: After reset the control readback is 2'b01 (bit 1 run = 0, bit 0 SCL release = 1). Also after reset: eng_rst = 1, scl_oe = 0, sda_oe = 0, bus_free = 1, stop_seen = 0.
- R2: A cycle with ctl_we high stores ctl_wdata[1:0], and ctl_rdata shows the stored value from the next cycle on.
- R3: While the run bit is 0, eng_rst is 1 and scl_oe equals the inverse of the release bit, whatever eng_scl_oe is.
- R4: While the run bit is 0, sda_oe is 0 whatever eng_sda_oe is.
- R5: In the first cycle after the run bit goes 0 to 1, eng_rst stays 1 and scl_oe and sda_oe are 0. From the next cycle, eng_rst is 0, scl_oe follows eng_scl_oe and sda_oe follows eng_sda_oe.
- R6: line_sts bit 0 is the SCL level and bit 1 is the SDA level, each passed through a two-flop synchroniser. A pin change shows on line_sts after the second rising clock edge, and not after the first.
- R7: A START (SDA 1 to 0 with SCL held at 1) clears bus_free and stop_seen. The change is visible after the third rising edge following the pin change.
- R8: A STOP (SDA 0 to 1 with SCL held at 1) sets bus_free and stop_seen. The change is visible after the third rising edge following the pin change.
- R9: SDA transitions while SCL is 0 leave bus_free and stop_seen unchanged.
- R10: A write with run = 0 while running asserts eng_rst in the next cycle and hands scl_oe to the written release bit at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| eng_scl_oe | input | 1 | Byte engine wants SCL pulled low |
| eng_sda_oe | input | 1 | Byte engine wants SDA pulled low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Write data: bit 1 run, bit 0 SCL release |
| ctl_rdata | output | 2 | Control register readback |
| line_sts | output | 2 | Synchronised levels: bit 1 SDA, bit 0 SCL |
| bus_free | output | 1 | High while no transfer is in progress |
| stop_seen | output | 1 | Set by STOP, cleared by START |
| eng_rst | output | 1 | Holds the byte engine in reset |
| scl_oe | output | 1 | Pull SCL low (open drain) |
| sda_oe | output | 1 | Pull SDA low (open drain) |

## Verification
The pin-ownership outputs depend on the register combinationally, so they are due one edge after a control write. The exception is the engine hand-back, which adds one more edge; it is checked on both of its cycles. Line readback is due two edges after a pin change and the bus flags three edges after. The bench changes each stimulus mid-cycle and counts rising edges before sampling. It also samples one edge early, to confirm that the result has not yet arrived. Each pin pattern in the sweeps is compared against values worked out from these latencies.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;

    typedef struct packed {
        logic run;
        logic scl_rel;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{run: 1'b0, scl_rel: 1'b1};

    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic free;
        logic stop_seen;
    } mon_t;

    localparam mon_t MON_RESET = '{scl_prev: 1'b1, sda_prev: 1'b1,
                                   free: 1'b1, stop_seen: 1'b0};

endpackage

// File: rtl/i2cbm_sync.sv
module i2cbm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.pipe[i] = sync_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign d_out = sync_q.pipe[LAST];

endmodule

// File: rtl/i2cbm_cond.sv
module i2cbm_cond
    import i2cbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic bus_free,
    output logic stop_seen
);

    mon_t mon_d, mon_q;
    logic start_det;
    logic stop_det;

    always_comb begin
        start_det = scl && mon_q.scl_prev && mon_q.sda_prev && !sda;
        stop_det  = scl && mon_q.scl_prev && !mon_q.sda_prev && sda;

        mon_d = mon_q;
        mon_d.scl_prev = scl;
        mon_d.sda_prev = sda;
        if (start_det) begin
            mon_d.free      = 1'b0;
            mon_d.stop_seen = 1'b0;
        end else if (stop_det) begin
            mon_d.free      = 1'b1;
            mon_d.stop_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= MON_RESET;
        else        mon_q <= mon_d;
    end

    assign bus_free  = mon_q.free;
    assign stop_seen = mon_q.stop_seen;

    AST_START_CLEARS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!bus_free && !stop_seen)); // R7

    AST_STOP_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (bus_free && stop_seen)); // R8

    AST_SCL_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !scl |=> ($stable(bus_free) && $stable(stop_seen))); // R9

endmodule

// File: rtl/i2cbm_ctl.sv
module i2cbm_ctl
    import i2cbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wdata,
    input  logic       eng_scl_oe,
    input  logic       eng_sda_oe,
    output logic [1:0] ctl_rd,
    output logic       eng_rst,
    output logic       scl_oe,
    output logic       sda_oe
);

    typedef struct packed {
        ctl_t ctl;
        logic active;
    } cst_t;

    cst_t st_d, st_q;
    logic engaged;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctl.run     = wdata[1];
            st_d.ctl.scl_rel = wdata[0];
        end
        st_d.active = st_q.ctl.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctl: CTL_RESET, active: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        engaged = st_q.ctl.run && st_q.active;
        eng_rst = !engaged;
        if (!st_q.ctl.run) begin
            scl_oe = !st_q.ctl.scl_rel;
            sda_oe = 1'b0;
        end else if (!st_q.active) begin
            scl_oe = 1'b0;
            sda_oe = 1'b0;
        end else begin
            scl_oe = eng_scl_oe;
            sda_oe = eng_sda_oe;
        end
    end

    assign ctl_rd = {st_q.ctl.run, st_q.ctl.scl_rel};

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_rd == $past(wdata))); // R2

    AST_SDA_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst |-> !sda_oe); // R4

    AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rd[1]) |-> (eng_rst && !scl_oe && !sda_oe)); // R5

    AST_FORCE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[1]) |=> (eng_rst && (scl_oe == !$past(wdata[0])))); // R10

endmodule

// File: rtl/i2c_busmon_recover.sv
module i2c_busmon_recover #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       eng_scl_oe,
    input  logic       eng_sda_oe,
    input  logic       ctl_we,
    input  logic [1:0] ctl_wdata,
    output logic [1:0] ctl_rdata,
    output logic [1:0] line_sts,
    output logic       bus_free,
    output logic       stop_seen,
    output logic       eng_rst,
    output logic       scl_oe,
    output logic       sda_oe
);

    localparam int LINES = 2;

    logic [LINES-1:0] lines_sync;

    i2cbm_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sda_i, scl_i}),
        .d_out (lines_sync)
    );

    i2cbm_cond i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (lines_sync[0]),
        .sda       (lines_sync[1]),
        .bus_free  (bus_free),
        .stop_seen (stop_seen)
    );

    i2cbm_ctl i_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_we),
        .wdata      (ctl_wdata),
        .eng_scl_oe (eng_scl_oe),
        .eng_sda_oe (eng_sda_oe),
        .ctl_rd     (ctl_rdata),
        .eng_rst    (eng_rst),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe)
    );

    assign line_sts = lines_sync;

    AST_RESET_MODE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[1] |-> (eng_rst && (scl_oe == !ctl_rdata[0]))); // R3

endmodule

// File: tb/test_i2c_busmon_recover.sv
`timescale 1ns/1ps
module test_i2c_busmon_recover;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_i = 1'b1, sda_i = 1'b1;
    logic       eng_scl_oe = 1'b0, eng_sda_oe = 1'b0;
    logic       ctl_we = 1'b0;
    logic [1:0] ctl_wdata = 2'b00;
    logic [1:0] ctl_rdata, line_sts;
    logic       bus_free, stop_seen, eng_rst, scl_oe, sda_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    i2c_busmon_recover i_i2c_busmon_recover (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .line_sts(line_sts), .bus_free(bus_free), .stop_seen(stop_seen),
        .eng_rst(eng_rst), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wr_ctl(input logic [1:0] v);
        ctl_we = 1'b1;
        ctl_wdata = v;
        step(1);
        ctl_we = 1'b0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 1);
        chk("R1 eng_rst", eng_rst, 1);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 bus_free", bus_free, 1);
        chk("R1 stop_seen", stop_seen, 0);

        // R3 R4 sweep in forced-reset mode
        for (int rel = 0; rel < 2; rel++) begin
            wr_ctl(2'(rel));
            for (int e = 0; e < 4; e++) begin
                eng_scl_oe = e[0];
                eng_sda_oe = e[1];
                #1;
                chk("R3 eng_rst", eng_rst, 1);
                chk("R3 scl_oe", scl_oe, 1 - rel);
                chk("R4 sda_oe", sda_oe, 0);
            end
        end

        // R5 hand-back to engine
        eng_scl_oe = 1'b1;
        eng_sda_oe = 1'b1;
        wr_ctl(2'b11);
        chk("R5 first eng_rst", eng_rst, 1);
        chk("R5 first scl_oe", scl_oe, 0);
        chk("R5 first sda_oe", sda_oe, 0);
        step(1);
        chk("R5 eng_rst", eng_rst, 0);
        for (int e = 0; e < 4; e++) begin
            eng_scl_oe = e[0];
            eng_sda_oe = e[1];
            #1;
            chk("R5 scl follow", scl_oe, e & 1);
            chk("R5 sda follow", sda_oe, (e >> 1) & 1);
        end

        // R10 force back into reset while running
        eng_scl_oe = 1'b0;
        eng_sda_oe = 1'b1;
        wr_ctl(2'b00);
        chk("R10 eng_rst", eng_rst, 1);
        chk("R10 scl_oe", scl_oe, 1);
        chk("R10 sda_oe", sda_oe, 0);
        wr_ctl(2'b01);
        chk("R10 scl released", scl_oe, 0);

        // R2 register sweep
        for (int v = 0; v < 4; v++) begin
            wr_ctl(2'(v));
            chk("R2 readback", ctl_rdata, v);
        end
        wr_ctl(2'b01);

        // R6 line readback latency
        for (int p = 0; p < 4; p++) begin
            int prev;
            prev = line_sts;
            scl_i = p[0];
            sda_i = p[1];
            step(1);
            chk("R6 not yet", line_sts, prev);
            step(1);
            chk("R6 readback", line_sts, p);
        end

        // R8 STOP: SCL low, SDA low, SCL high, SDA high
        scl_i = 1'b0; step(3);
        sda_i = 1'b0; step(3);
        scl_i = 1'b1; step(3);
        sda_i = 1'b1; step(2);
        chk("R8 before", stop_seen, 0);
        step(1);
        chk("R8 bus_free", bus_free, 1);
        chk("R8 stop_seen", stop_seen, 1);

        // R9 SDA toggles while SCL low, bus free
        scl_i = 1'b0; step(3);
        for (int k = 0; k < 4; k++) begin
            sda_i = ~sda_i;
            step(3);
            chk("R9 free idle", bus_free, 1);
            chk("R9 stop idle", stop_seen, 1);
        end
        sda_i = 1'b1; step(3);
        scl_i = 1'b1; step(3);

        // R7 START
        sda_i = 1'b0; step(2);
        chk("R7 before", bus_free, 1);
        step(1);
        chk("R7 bus_free", bus_free, 0);
        chk("R7 stop_seen", stop_seen, 0);

        // R9 SDA toggles while SCL low, bus busy
        scl_i = 1'b0; step(3);
        for (int k = 0; k < 4; k++) begin
            sda_i = ~sda_i;
            step(3);
            chk("R9 free busy", bus_free, 0);
            chk("R9 stop busy", stop_seen, 0);
        end

        // R8 closing STOP
        sda_i = 1'b0; step(3);
        scl_i = 1'b1; step(3);
        sda_i = 1'b1; step(3);
        chk("R8 final free", bus_free, 1);
        chk("R8 final stop", stop_seen, 1);

        summary();
    end

endmodule